// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block takes a processor from power-on or an external reset to its first instruction fetch. After power-on it waits for a fixed number of input-clock cycles, counted only while the supply is reported good, so the on-chip clock multiplier can lock. While it waits, and while an accepted external reset is held, it empties the stack pointers, clears the mode/status register and masks every interrupt.

When reset is released, the block samples the bus-request input and the memory-map strap. If a bus request is pending, it waits until the request drops. It then either starts the byte-wide boot loader or enables fetch directly. The first fetch is always from address 0x0000.

The block also runs power-down. It acknowledges entry to power-down and, on a wake request, holds off execution for a fixed recovery count. External reset pulses shorter than a minimum width are filtered out.

Top module: `boot_seq_top`

## Requirements
- R1: After power-on reset, `fetch_en_o` stays low until `pwr_ok_i` has been high for LOCK_CYCLES (default 2000) clock edges. Fetch may begin no earlier than the edge after that.
- R2: During the lock wait and during an accepted external reset, `stk_clr_o`, `stat_clr_o` and `irq_mask_o` are all 1.
- R3: On release with `bus_req_i`=0 and `map_strap_i`=0, `boot_start_o` goes to 1 after the next edge and holds until `boot_done_i` is sampled high. `fetch_en_o` rises on the edge that samples `boot_done_i`, and `boot_start_o` falls on the same edge.
- R4: On release with `bus_req_i`=0 and `map_strap_i`=1, `fetch_en_o` goes to 1 after the next edge, and `boot_start_o` never rises.
- R5: On release with `bus_req_i`=1, the block holds. In the hold, `boot_start_o`=0, `fetch_en_o`=0 and `irq_mask_o`=1. On the edge after `bus_req_i` drops, it decides as in R3 or R4, using the strap value at that edge.
- R6: `fetch_addr_o` is always START_ADDR (default 0x0000).
- R7: A reset accepted after the lock wait does not repeat the lock wait. The decision is taken on the first edge that samples `ext_rst_ni` high.
- R8: If `ext_rst_ni` is low for fewer than MIN_RST_W (default 4) consecutive edges, the outputs do not change. If it is low for exactly MIN_RST_W edges, the reset is accepted after the last of those edges.
- R9: When `pd_req_i` is sampled while running, `pd_ack_o` goes to 1 and `fetch_en_o` to 0 after that edge. After the edge that samples `pd_wake_i`, `pd_ack_o` stays 1 for PD_RECOVER (default 300) cycles. Then `fetch_en_o` rises and `pd_ack_o` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Power-on asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply good; enables the lock counter |
| ext_rst_ni | input | 1 | External reset request, active low, width-filtered |
| bus_req_i | input | 1 | External bus request |
| map_strap_i | input | 1 | Memory-map strap: 0 selects boot loading, 1 selects direct run |
| boot_done_i | input | 1 | Boot loader finished |
| pd_req_i | input | 1 | Power-down request |
| pd_wake_i | input | 1 | Power-down release |
| stk_clr_o | output | 1 | Empty the stack pointers |
| irq_mask_o | output | 1 | Global interrupt mask |
| stat_clr_o | output | 1 | Clear the mode/status register |
| boot_start_o | output | 1 | Request to the boot loader |
| fetch_en_o | output | 1 | Instruction fetch enable |
| fetch_addr_o | output | ADDR_W | Start fetch address |
| pd_ack_o | output | 1 | Power-down acknowledge |

## Verification
Every output is registered state, so each result is due exactly one edge after the input edge that causes it. The exceptions are the timed windows: the lock wait is due LOCK_CYCLES+1 edges after `pwr_ok_i` rises, reset acceptance is due on the MIN_RST_W-th low edge, and wake recovery is due PD_RECOVER edges after the wake edge. A behavioural model steps at each rising edge, and all outputs are compared 2 ns after that edge. Inputs change only on falling edges. The directed checks count edges to these exact boundaries and sample on both sides of each one.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_LOCK, ST_RST, ST_HOLD, ST_BOOT, ST_RUN, ST_PD, ST_WAKE
  } seq_state_e;
endpackage

// File: rtl/rst_width_filter.sv
module rst_width_filter #(
  parameter int MIN_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  output logic accept_o
);
  localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [CW-1:0] TOP = CW'(MIN_W - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= '0;
    else if (ext_rst_ni)  low_cnt <= '0;
    else if (low_cnt != TOP) low_cnt <= low_cnt + 1'b1;
  end

  // accepted on the MIN_W-th consecutive low edge
  assign accept_o = !ext_rst_ni && (low_cnt == TOP);
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int LIMIT   = 300,
  parameter bit ON_LAST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (clr_i)              cnt <= '0;
    else if (en_i && cnt != LIM) cnt <= cnt + 1'b1;
  end

  generate
    if (ON_LAST) begin : g_last
      assign hit_o = en_i && (cnt == LIM - 1'b1);
    end else begin : g_done
      assign hit_o = (cnt == LIM);
    end
  endgenerate
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       rst_accept_i,
  input  logic       lock_done_i,
  input  logic       wake_last_i,
  input  logic       bus_req_i,
  input  logic       map_strap_i,
  input  logic       boot_done_i,
  input  logic       pd_req_i,
  input  logic       pd_wake_i,
  output seq_state_e state_o,
  output logic       stk_clr_o,
  output logic       irq_mask_o,
  output logic       stat_clr_o,
  output logic       boot_start_o,
  output logic       fetch_en_o,
  output logic       pd_ack_o
);
  seq_state_e st_q, st_d;

  function automatic seq_state_e launch(input logic req, input logic strap);
    if (req)        return ST_HOLD;
    else if (!strap) return ST_BOOT;
    else            return ST_RUN;
  endfunction

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCK: if (lock_done_i && ext_rst_ni) st_d = launch(bus_req_i, map_strap_i);
      ST_RST:  if (ext_rst_ni)  st_d = launch(bus_req_i, map_strap_i);
      ST_HOLD: if (!bus_req_i)  st_d = launch(1'b0, map_strap_i);
      ST_BOOT: if (boot_done_i) st_d = ST_RUN;
      ST_RUN:  if (pd_req_i)    st_d = ST_PD;
      ST_PD:   if (pd_wake_i)   st_d = ST_WAKE;
      ST_WAKE: if (wake_last_i) st_d = ST_RUN;
      default: st_d = ST_LOCK;
    endcase
    if (rst_accept_i && st_q != ST_LOCK) st_d = ST_RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCK;
    else         st_q <= st_d;
  end

  assign state_o      = st_q;
  assign stk_clr_o    = (st_q == ST_LOCK) || (st_q == ST_RST);
  assign stat_clr_o   = stk_clr_o;
  assign irq_mask_o   = stk_clr_o || (st_q == ST_HOLD) || (st_q == ST_BOOT);
  assign boot_start_o = (st_q == ST_BOOT);
  assign fetch_en_o   = (st_q == ST_RUN);
  assign pd_ack_o     = (st_q == ST_PD) || (st_q == ST_WAKE);

  AST_FETCH_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |-> lock_done_i); // R1
  AST_MASK_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_accept_i |=> (irq_mask_o && stk_clr_o && stat_clr_o)); // R2
  AST_BOOT_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_start_o && boot_done_i && !rst_accept_i) |=> (fetch_en_o && !boot_start_o)); // R3
  AST_HOLD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_o && !stk_clr_o && !boot_start_o && bus_req_i) |=> (!fetch_en_o && !boot_start_o)); // R5
  AST_PD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_ack_o) |-> (fetch_en_o || stk_clr_o)); // R9
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int          LOCK_CYCLES = 2000,
  parameter int          MIN_RST_W   = 4,
  parameter int          PD_RECOVER  = 300,
  parameter int          ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ext_rst_ni,
  input  logic              bus_req_i,
  input  logic              map_strap_i,
  input  logic              boot_done_i,
  input  logic              pd_req_i,
  input  logic              pd_wake_i,
  output logic              stk_clr_o,
  output logic              irq_mask_o,
  output logic              stat_clr_o,
  output logic              boot_start_o,
  output logic              fetch_en_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              pd_ack_o
);
  logic       rst_accept, lock_done, wake_last;
  seq_state_e state;

  rst_width_filter #(.MIN_W(MIN_RST_W)) u_filt (
    .clk_i, .rst_ni, .ext_rst_ni, .accept_o(rst_accept)
  );

  cycle_timer #(.LIMIT(LOCK_CYCLES), .ON_LAST(1'b0)) u_lock (
    .clk_i, .rst_ni, .clr_i(1'b0), .en_i(pwr_ok_i), .hit_o(lock_done)
  );

  cycle_timer #(.LIMIT(PD_RECOVER), .ON_LAST(1'b1)) u_wake (
    .clk_i, .rst_ni, .clr_i(state != ST_WAKE), .en_i(state == ST_WAKE), .hit_o(wake_last)
  );

  boot_seq_fsm u_fsm (
    .clk_i, .rst_ni, .ext_rst_ni,
    .rst_accept_i(rst_accept), .lock_done_i(lock_done), .wake_last_i(wake_last),
    .bus_req_i, .map_strap_i, .boot_done_i, .pd_req_i, .pd_wake_i,
    .state_o(state),
    .stk_clr_o, .irq_mask_o, .stat_clr_o, .boot_start_o, .fetch_en_o, .pd_ack_o
  );

  assign fetch_addr_o = START_ADDR;
endmodule

// File: tb/tb_boot_seq_top.sv
module tb_boot_seq_top;
  localparam int LOCK = 2000, MINW = 4, REC = 300, AW = 14;
  localparam int M_LOCK = 0, M_RST = 1, M_HOLD = 2, M_BOOT = 3, M_RUN = 4, M_PD = 5, M_WAKE = 6;

  logic clk = 0, rst_n = 0;
  logic pwr_ok = 0, ext_n = 0, bus = 0, strap = 1, done = 0, pdr = 0, pdw = 0;
  logic stk, mask, stat, boot, fetch, pdack;
  logic [AW-1:0] addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  boot_seq_top #(.LOCK_CYCLES(LOCK), .MIN_RST_W(MINW), .PD_RECOVER(REC), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .ext_rst_ni(ext_n), .bus_req_i(bus),
    .map_strap_i(strap), .boot_done_i(done), .pd_req_i(pdr), .pd_wake_i(pdw),
    .stk_clr_o(stk), .irq_mask_o(mask), .stat_clr_o(stat), .boot_start_o(boot),
    .fetch_en_o(fetch), .fetch_addr_o(addr), .pd_ack_o(pdack));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // reference model, stepped on every rising edge
  int ms = M_LOCK, ml = 0, mlo = 0, mr = 0;
  function automatic int pick(logic r, logic s);
    if (r) return M_HOLD;
    return s ? M_RUN : M_BOOT;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = M_LOCK; ml = 0; mlo = 0; mr = 0;
    end else begin
      int nlo, nst;
      bit acc;
      nlo = ext_n ? 0 : ((mlo < MINW) ? mlo + 1 : MINW);
      acc = (nlo == MINW);
      nst = ms;
      case (ms)
        M_LOCK: if (ml == LOCK && ext_n) nst = pick(bus, strap);
        M_RST:  if (ext_n) nst = pick(bus, strap);
        M_HOLD: if (!bus) nst = pick(1'b0, strap);
        M_BOOT: if (done) nst = M_RUN;
        M_RUN:  if (pdr) nst = M_PD;
        M_PD:   if (pdw) nst = M_WAKE;
        M_WAKE: if (mr == REC - 1) nst = M_RUN;
        default: ;
      endcase
      if (acc && ms != M_LOCK) nst = M_RST;
      mr = (ms == M_WAKE && nst == M_WAKE) ? mr + 1 : 0;
      if (pwr_ok && ml < LOCK) ml++;
      mlo = nlo;
      ms = nst;
    end
    #2;
    if (rst_n) begin
      check("R2 stk_clr", int'(stk), int'(ms == M_LOCK || ms == M_RST));
      check("R2 stat_clr", int'(stat), int'(ms == M_LOCK || ms == M_RST));
      check("R2 irq_mask", int'(mask), int'(ms <= M_BOOT));
      check("R3 boot_start", int'(boot), int'(ms == M_BOOT));
      check("R4 fetch_en", int'(fetch), int'(ms == M_RUN));
      check("R6 fetch_addr", int'(addr), 0);
      check("R9 pd_ack", int'(pdack), int'(ms == M_PD || ms == M_WAKE));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ext_reset(int low_edges);
    @(negedge clk); ext_n = 0;
    tick(low_edges);
    @(negedge clk); ext_n = 1;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    check("R2 power-on mask", int'(mask && stk && stat), 1);
    check("R1 no fetch in reset", int'(fetch), 0);
    @(negedge clk); rst_n = 1; ext_n = 1;
    tick(50);
    check("R1 no count without pwr_ok", int'(fetch), 0);
    @(negedge clk); pwr_ok = 1;
    tick(2000);
    check("R1 still locking", int'(fetch), 0);
    check("R2 clears during lock", int'(stk && stat && mask), 1);
    tick(1);
    check("R1 fetch after lock", int'(fetch), 1);
    check("R4 direct no boot", int'(boot), 0);
    check("R6 start address", int'(addr), 0);
    // R8 short pulse ignored
    ext_reset(MINW - 1);
    tick(1);
    check("R8 short pulse fetch", int'(fetch), 1);
    check("R8 short pulse mask", int'(mask), 0);
    // R8 exact width accepted
    @(negedge clk); ext_n = 0;
    tick(MINW - 1);
    check("R8 not yet accepted", int'(mask), 0);
    tick(1);
    check("R8 accepted at width", int'(mask && stk && stat), 1);
    tick(20);
    @(negedge clk); ext_n = 1;
    tick(1);
    check("R7 no relock", int'(fetch), 1);
    // R3 boot path
    @(negedge clk); strap = 0;
    ext_reset(MINW);
    tick(1);
    check("R3 boot start", int'(boot), 1);
    check("R3 no fetch in boot", int'(fetch), 0);
    tick(10);
    check("R3 boot holds", int'(boot), 1);
    @(negedge clk); done = 1;
    tick(1);
    check("R3 fetch after boot", int'(fetch), 1);
    check("R3 boot drops", int'(boot), 0);
    @(negedge clk); done = 0;
    // R5 hold on bus request
    @(negedge clk); strap = 1; bus = 1;
    ext_reset(MINW);
    tick(5);
    check("R5 hold no fetch", int'(fetch || boot), 0);
    check("R5 hold masked", int'(mask), 1);
    check("R5 hold not clearing", int'(stk), 0);
    @(negedge clk); strap = 0; bus = 0;
    tick(1);
    check("R5 re-evaluates strap", int'(boot), 1);
    @(negedge clk); done = 1;
    tick(1);
    @(negedge clk); done = 0;
    check("R3 fetch after held boot", int'(fetch), 1);
    // R9 power-down and recovery
    @(negedge clk); pdr = 1;
    tick(1);
    check("R9 pd ack", int'(pdack), 1);
    check("R9 fetch off", int'(fetch), 0);
    @(negedge clk); pdr = 0;
    tick(20);
    check("R9 stays down", int'(pdack), 1);
    @(negedge clk); pdw = 1;
    tick(1);
    @(negedge clk); pdw = 0;
    tick(REC - 1);
    check("R9 recovering", int'(pdack), 1);
    check("R9 no early fetch", int'(fetch), 0);
    tick(1);
    check("R9 fetch after recovery", int'(fetch), 1);
    check("R9 ack drops", int'(pdack), 0);
    // R2 reset during power-down
    @(negedge clk); pdr = 1; strap = 1;
    tick(1);
    @(negedge clk); pdr = 0; ext_n = 0;
    tick(MINW);
    check("R2 reset in pd", int'(stk && !pdack), 1);
    @(negedge clk); ext_n = 1;
    tick(1);
    check("R7 run after pd reset", int'(fetch), 1);
    tick(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule